// File: doc/BRIEF.md
# Three-Channel Timer Register Front End

This block is the register-side front end of a timer with three independent down-counting channels. A processor reaches it over an 8-bit data bus through an active-low chip select, a two-bit port address and active-low write and read strobes. Three of the four ports belong to the channels. Each channel keeps its own divisor. The fourth port is a single control register shared by all channels. Each control word carries a channel field that says which channel it configures.

Every channel must receive a control word before it accepts a divisor. A 16-bit divisor normally arrives as two bytes on the channel's port, low byte first. The processor can read the running count back through the same port at any time, and the bytes come back in the order set by the channel's access mode. Each channel counts on the system clock whenever the shared count enable and its own gate are both high. The channel drives one output whose waveform depends on the operating mode that was programmed: terminal count, rate pulse or square wave.

Top module: `tmr_bus_if`

## Requirements
- R1: While cs_n is low, addr 0, 1 and 2 reach channels 0, 1 and 2, and addr 3 reaches the control register. While cs_n is high, wr_n and rd_n have no effect and dout is 0.
- R2: A control word holds these fields. Bit [0] is the count format: 1 means decimal (BCD). Bits [3:1] are the operating mode. Bits [5:4] are the byte access: 01 means low byte only, 10 means high byte only, 11 means low byte then high byte. Bits [7:6] are the target channel. A word with [5:4]=00 or [7:6]=11 changes no channel state.
- R3: After reset no channel is configured, every tmr_out is high and every count reads 0. Data writes to a channel before its first control word are discarded.
- R4: In low-then-high access, a per-channel byte pointer alternates on each data write or read of that channel. A control word for that channel returns the pointer to the low byte. A divisor takes effect only when the last byte its access mode calls for has been written. It is then copied into the count on the next counting tick.
- R5: A channel read returns the current count. It gives the low byte alone, the high byte alone, or the low byte and then the high byte through the shared pointer, following the access mode. dout is 0 when no read is under way or when addr is 3.
- R6: Terminal-count mode (mode bits [2:1] of the word equal 00 or 01): tmr_out goes low when the control word is written and again when each divisor is completed. With divisor N it rises on the tick that takes the count from 1 to 0, which is N+1 ticks after the divisor is completed, and then stays high.
- R7: A counting tick is a clock edge with cnt_en and the channel's gate both high. On any other edge the channel's count and tmr_out hold.
- R8: Rate mode (mode bits [2:1] equal 10): tmr_out is high after the control word. Once divisor N is loaded, tmr_out is low for exactly one tick each time the count reaches 1 and reloads N, which gives a period of N ticks.
- R9: Square mode (mode bits [2:1] equal 11): tmr_out is high after the control word. Once divisor N is loaded, tmr_out is high for ceil(N/2) ticks and low for floor(N/2) ticks, repeating every N ticks.
- R10: With the format bit set, the count decrements as four decimal digits, one per nibble (0x1000 becomes 0x0999). With the format bit clear, it decrements in binary (0x1000 becomes 0x0FFF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; counting ticks are qualified edges of it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 2 | Port address: channel 0..2 or control register |
| wr_n | input | 1 | Active-low write strobe, one access per low cycle |
| rd_n | input | 1 | Active-low read strobe, one access per low cycle |
| din | input | 8 | Write data: control word or divisor byte |
| dout | output | 8 | Read data: selected count byte, 0 when idle |
| cnt_en | input | 1 | Shared count enable for all channels |
| gate | input | 3 | Per-channel gate; low suspends counting |
| tmr_out | output | 3 | Per-channel timer output |

## Verification
The hardest state to reach from the ports is a byte sequence left half finished. Examples are a low byte followed by a fresh control word, or a read-back command arriving between the two halves of a divisor. In both cases the only trace is which half the next byte lands in. The stimulus puts these interruptions between divisor bytes and then measures the terminal-count delay, which shows which divisor was actually loaded. To read a running count at a known value, the bench lowers the channel's gate after an exact number of ticks and reads both bytes while the count is frozen.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

   localparam int ADDR_W = 2;
   localparam int CHAN_W = 2;
   localparam int CTRL_W = 8;
   localparam logic [ADDR_W-1:0] CTRL_ADDR = 2'b11;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'b00,
      ACC_LO    = 2'b01,
      ACC_HI    = 2'b10,
      ACC_WORD  = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      BEH_TERM   = 2'd0,
      BEH_RATE   = 2'd1,
      BEH_SQUARE = 2'd2
   } beh_e;

   typedef struct packed {
      logic [CHAN_W-1:0] chan;
      acc_e              acc;
      logic [2:0]        mode;
      logic              bcd;
   } ctrl_t;

   function automatic beh_e mode_to_beh(input logic [2:0] m);
      beh_e b;
      case (m[1:0])
         2'b10:   b = BEH_RATE;
         2'b11:   b = BEH_SQUARE;
         default: b = BEH_TERM;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/tmr_dec.sv
`timescale 1ns/1ps
module tmr_dec
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 8
) (
   input  logic                     cs_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     wr_n,
   input  logic                     rd_n,
   input  logic [DATA_W-1:0]        din,
   output logic [NUM_CH-1:0]        ctl_we,
   output logic [NUM_CH-1:0]        dat_we,
   output logic [NUM_CH-1:0]        dat_re
);

   ctrl_t cw;
   logic  wr_act;
   logic  rd_act;
   logic  ctl_hit;

   assign cw      = ctrl_t'(din);
   assign wr_act  = !cs_n && !wr_n;
   assign rd_act  = !cs_n && !rd_n && wr_n;
   assign ctl_hit = wr_act && (addr == CTRL_ADDR) && (cw.acc != ACC_LATCH);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      assign ctl_we[i] = ctl_hit && (cw.chan == CHAN_W'(i));
      assign dat_we[i] = wr_act && (addr == ADDR_W'(i));
      assign dat_re[i] = rd_act && (addr == ADDR_W'(i));
   end

endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter bit BCD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  ctrl_t             cw,
   input  logic              dat_we,
   input  logic              dat_re,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cnt_en,
   input  logic              gate,
   output logic [DATA_W-1:0] rdata,
   output logic              tout
);

   localparam int CNT_W  = 2 * DATA_W;
   localparam int DIGITS = CNT_W / 4;
   localparam int MAG_W  = CNT_W + 1;

   function automatic logic [CNT_W-1:0] dec_bcd(input logic [CNT_W-1:0] v);
      logic [CNT_W-1:0] r;
      logic             borrow;
      r      = v;
      borrow = 1'b1;
      for (int d = 0; d < DIGITS; d++) begin
         if (borrow) begin
            if (v[d*4 +: 4] == 4'd0) begin
               r[d*4 +: 4] = 4'd9;
            end else begin
               r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
               borrow      = 1'b0;
            end
         end
      end
      return r;
   endfunction

   function automatic logic [MAG_W-1:0] magnitude(input logic [CNT_W-1:0] v,
                                                  input logic dec);
      logic [MAG_W-1:0] acc;
      logic [MAG_W-1:0] wt;
      acc = '0;
      wt  = MAG_W'(1);
      for (int d = 0; d < DIGITS; d++) begin
         acc = acc + MAG_W'(v[d*4 +: 4]) * wt;
         wt  = wt * MAG_W'(10);
      end
      if (!dec) acc = MAG_W'(v);
      if (v == '0) acc = dec ? wt : (MAG_W'(1) << CNT_W);
      return acc;
   endfunction

   logic              cfg_q;
   acc_e              acc_q;
   beh_e              beh_q;
   logic              bcd_q;
   logic              ptr_q;
   logic [DATA_W-1:0] lo_stage_q;
   logic [CNT_W-1:0]  div_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              load_q;
   logic              armed_q;
   logic              out_q;

   logic              dec_mode;
   logic              tick;
   logic              wr_done;
   logic              sq_hi;
   logic [CNT_W-1:0]  cnt_dec;

   if (BCD_EN) begin : g_bcd
      assign dec_mode = bcd_q;
   end else begin : g_bin
      assign dec_mode = 1'b0;
   end

   assign tick    = cnt_en && gate && cfg_q;
   assign wr_done = dat_we && cfg_q && ((acc_q != ACC_WORD) || ptr_q);
   assign cnt_dec = dec_mode ? dec_bcd(cnt_q) : (cnt_q - CNT_W'(1));
   assign sq_hi   = magnitude(cnt_q, dec_mode) > (magnitude(div_q, dec_mode) >> 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q      <= 1'b0;
         acc_q      <= ACC_LATCH;
         beh_q      <= BEH_TERM;
         bcd_q      <= 1'b0;
         ptr_q      <= 1'b0;
         lo_stage_q <= '0;
         div_q      <= '0;
         cnt_q      <= '0;
         load_q     <= 1'b0;
         armed_q    <= 1'b0;
         out_q      <= 1'b1;
      end else begin
         if (tick) begin
            if (load_q) begin
               cnt_q   <= div_q;
               armed_q <= 1'b1;
               load_q  <= 1'b0;
            end else if (armed_q) begin
               if ((beh_q != BEH_TERM) && (cnt_q == CNT_W'(1))) begin
                  cnt_q <= div_q;
                  if (beh_q == BEH_RATE) out_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_dec;
                  if (beh_q == BEH_RATE) out_q <= 1'b1;
                  if ((beh_q == BEH_TERM) && (cnt_q == CNT_W'(1))) out_q <= 1'b1;
               end
            end
         end
         if (dat_we && cfg_q) begin
            case (acc_q)
               ACC_LO:   div_q <= {{DATA_W{1'b0}}, wdata};
               ACC_HI:   div_q <= {wdata, {DATA_W{1'b0}}};
               ACC_WORD: begin
                  if (ptr_q) div_q      <= {wdata, lo_stage_q};
                  else       lo_stage_q <= wdata;
               end
               default: ;
            endcase
            if (acc_q == ACC_WORD) ptr_q <= ~ptr_q;
            if (wr_done) begin
               load_q <= 1'b1;
               if (beh_q == BEH_TERM) out_q <= 1'b0;
            end
         end else if (dat_re && cfg_q && (acc_q == ACC_WORD)) begin
            ptr_q <= ~ptr_q;
         end
         if (ctl_we) begin
            cfg_q   <= 1'b1;
            acc_q   <= cw.acc;
            beh_q   <= mode_to_beh(cw.mode);
            bcd_q   <= cw.bcd;
            ptr_q   <= 1'b0;
            load_q  <= 1'b0;
            armed_q <= 1'b0;
            out_q   <= (mode_to_beh(cw.mode) == BEH_TERM) ? 1'b0 : 1'b1;
         end
      end
   end

   always_comb begin
      case (acc_q)
         ACC_HI:   rdata = cnt_q[CNT_W-1 -: DATA_W];
         ACC_WORD: rdata = ptr_q ? cnt_q[CNT_W-1 -: DATA_W] : cnt_q[DATA_W-1:0];
         default:  rdata = cnt_q[DATA_W-1:0];
      endcase
   end

   assign tout = (beh_q == BEH_SQUARE) ? (armed_q ? sq_hi : 1'b1) : out_q;

endmodule

// File: rtl/tmr_rdmux.sv
`timescale 1ns/1ps
module tmr_rdmux #(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 8
) (
   input  logic [NUM_CH-1:0] sel,
   input  logic [DATA_W-1:0] ch_data [NUM_CH],
   output logic [DATA_W-1:0] dout
);

   always_comb begin
      dout = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (sel[i]) dout = dout | ch_data[i];
      end
   end

endmodule

// File: rtl/tmr_bus_if.sv
`timescale 1ns/1ps
module tmr_bus_if
   import tmr_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 8,
   parameter bit BCD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic [1:0]        addr,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   input  logic              cnt_en,
   input  logic [NUM_CH-1:0] gate,
   output logic [NUM_CH-1:0] tmr_out
);

   if (DATA_W != CTRL_W) begin : g_bad_width
      $error("tmr_bus_if: DATA_W must equal the control word width");
   end
   if ((NUM_CH < 1) || (NUM_CH > (1 << ADDR_W) - 1)) begin : g_bad_count
      $error("tmr_bus_if: NUM_CH must leave one port for control");
   end

   logic [NUM_CH-1:0] ctl_we;
   logic [NUM_CH-1:0] dat_we;
   logic [NUM_CH-1:0] dat_re;
   logic [DATA_W-1:0] ch_data [NUM_CH];
   ctrl_t             cw;

   assign cw = ctrl_t'(din);

   tmr_dec #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dec (
      .cs_n   (cs_n),
      .addr   (addr),
      .wr_n   (wr_n),
      .rd_n   (rd_n),
      .din    (din),
      .ctl_we (ctl_we),
      .dat_we (dat_we),
      .dat_re (dat_re)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      tmr_chan #(.DATA_W(DATA_W), .BCD_EN(BCD_EN)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .ctl_we (ctl_we[i]),
         .cw     (cw),
         .dat_we (dat_we[i]),
         .dat_re (dat_re[i]),
         .wdata  (din),
         .cnt_en (cnt_en),
         .gate   (gate[i]),
         .rdata  (ch_data[i]),
         .tout   (tmr_out[i])
      );
   end

   tmr_rdmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rdmux (
      .sel     (dat_re),
      .ch_data (ch_data),
      .dout    (dout)
   );

endmodule

// File: rtl/tmr_bus_if_chk.sv
`timescale 1ns/1ps
module tmr_bus_if_chk #(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic [1:0]        addr,
   input logic              wr_n,
   input logic              rd_n,
   input logic [DATA_W-1:0] din,
   input logic [DATA_W-1:0] dout,
   input logic              cnt_en,
   input logic [NUM_CH-1:0] gate,
   input logic [NUM_CH-1:0] tmr_out
);

   p_dout_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || rd_n || !wr_n || (addr == 2'b11)) |-> (dout == '0));

   p_out_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(tmr_out) && !$isunknown(dout));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      p_ctl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (!cs_n && !wr_n && (addr == 2'b11) && (din[7:6] == 2'(i)) &&
          (din[5:4] != 2'b00) && !din[2]) |=> !tmr_out[i]);

      p_ctl_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (!cs_n && !wr_n && (addr == 2'b11) && (din[7:6] == 2'(i)) &&
          (din[5:4] != 2'b00) && din[2]) |=> tmr_out[i]);

      p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!(cnt_en && gate[i]) && (cs_n || wr_n)) |=> (tmr_out[i] == $past(tmr_out[i])));
   end

endmodule

bind tmr_bus_if tmr_bus_if_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_n    (cs_n),
   .addr    (addr),
   .wr_n    (wr_n),
   .rd_n    (rd_n),
   .din     (din),
   .dout    (dout),
   .cnt_en  (cnt_en),
   .gate    (gate),
   .tmr_out (tmr_out)
);

// File: tb/tb_tmr_bus_if.sv
`timescale 1ns/1ps
module tb_tmr_bus_if;

   localparam int WD_CYC = 20000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cs_n;
   logic [1:0] addr;
   logic       wr_n;
   logic       rd_n;
   logic [7:0] din;
   logic [7:0] dout;
   logic       cnt_en;
   logic [2:0] gate;
   logic [2:0] tmr_out;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] b;

   always #2 clk = ~clk;

   tmr_bus_if dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (cs_n),
      .addr    (addr),
      .wr_n    (wr_n),
      .rd_n    (rd_n),
      .din     (din),
      .dout    (dout),
      .cnt_en  (cnt_en),
      .gate    (gate),
      .tmr_out (tmr_out)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1; din = 8'h00;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      cs_n = 1'b0; rd_n = 1'b0; addr = a;
      #1 d = dout;
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      check("R3", "outputs after reset", 16'(tmr_out), 16'h0007);
      check("R5", "dout idle after reset", 16'(dout), 16'h0000);
   endtask

   task automatic t_chip_select;
      cs_n = 1'b1; wr_n = 1'b0; addr = 2'b11; din = 8'h30;
      @(negedge clk);
      wr_n = 1'b1; din = 8'h00;
      check("R1", "control write with cs_n high ignored", 16'(tmr_out[0]), 16'h1);
      rd_n = 1'b0; addr = 2'b00;
      #1 check("R1", "dout with cs_n high", 16'(dout), 16'h0000);
      @(negedge clk);
      rd_n = 1'b1;
   endtask

   task automatic t_uninit;
      wr(2'd2, 8'h34);
      wr(2'd2, 8'h12);
      wr(2'd3, 8'hB0);
      check("R3", "ch2 low after control word", 16'(tmr_out[2]), 16'h0);
      idle(5);
      check("R3", "early divisor not loaded", 16'(tmr_out[2]), 16'h0);
      rd(2'd2, b); check("R3", "ch2 count low byte", 16'(b), 16'h00);
      rd(2'd2, b); check("R3", "ch2 count high byte", 16'(b), 16'h00);
   endtask

   task automatic t_term;
      wr(2'd3, 8'h30);
      check("R6", "low after control word", 16'(tmr_out[0]), 16'h0);
      wr(2'd0, 8'h05);
      wr(2'd0, 8'h00);
      idle(5);
      check("R6", "still low at count 1", 16'(tmr_out[0]), 16'h0);
      idle(1);
      check("R6", "high at terminal count", 16'(tmr_out[0]), 16'h1);
      check("R1", "other channel untouched", 16'(tmr_out[1]), 16'h1);
      idle(10);
      check("R6", "stays high", 16'(tmr_out[0]), 16'h1);
   endtask

   task automatic t_pointer;
      wr(2'd3, 8'h30);
      wr(2'd0, 8'h44);
      wr(2'd3, 8'h30);
      wr(2'd0, 8'h06);
      wr(2'd3, 8'h00);
      wr(2'd0, 8'h00);
      idle(6);
      check("R4", "pointer reset, divisor 6 not yet done", 16'(tmr_out[0]), 16'h0);
      idle(1);
      check("R2", "latch word ignored mid divisor", 16'(tmr_out[0]), 16'h1);
   endtask

   task automatic t_gate;
      gate[1] = 1'b0;
      wr(2'd3, 8'h70);
      wr(2'd1, 8'h03);
      wr(2'd1, 8'h00);
      idle(6);
      check("R7", "no load while gate low", 16'(tmr_out[1]), 16'h0);
      gate[1] = 1'b1;
      idle(2);
      gate[1] = 1'b0;
      idle(6);
      check("R7", "paused mid count", 16'(tmr_out[1]), 16'h0);
      rd(2'd1, b); check("R5", "frozen count low byte", 16'(b), 16'h02);
      rd(2'd1, b); check("R5", "frozen count high byte", 16'(b), 16'h00);
      gate[1] = 1'b1;
      idle(1);
      check("R7", "resumed, count 1", 16'(tmr_out[1]), 16'h0);
      idle(1);
      check("R7", "resumed, terminal", 16'(tmr_out[1]), 16'h1);
   endtask

   task automatic t_bcd;
      gate[0] = 1'b1;
      wr(2'd3, 8'h31);
      wr(2'd0, 8'h00);
      wr(2'd0, 8'h10);
      idle(3);
      gate[0] = 1'b0;
      rd(2'd0, b); check("R10", "decimal low byte", 16'(b), 16'h98);
      rd(2'd0, b); check("R10", "decimal high byte", 16'(b), 16'h09);
      gate[0] = 1'b1;
      wr(2'd3, 8'h30);
      wr(2'd0, 8'h00);
      wr(2'd0, 8'h10);
      idle(3);
      gate[0] = 1'b0;
      rd(2'd0, b); check("R10", "binary low byte", 16'(b), 16'hFE);
      rd(2'd0, b); check("R10", "binary high byte", 16'(b), 16'h0F);
   endtask

   task automatic t_access;
      gate[2] = 1'b1;
      wr(2'd3, 8'h90);
      wr(2'd2, 8'h07);
      idle(1);
      gate[2] = 1'b0;
      rd(2'd2, b); check("R5", "low-only first read", 16'(b), 16'h07);
      rd(2'd2, b); check("R5", "low-only second read", 16'(b), 16'h07);
      wr(2'd3, 8'hA0);
      wr(2'd2, 8'h12);
      gate[2] = 1'b1;
      idle(1);
      gate[2] = 1'b0;
      rd(2'd2, b); check("R2", "high-only first read", 16'(b), 16'h12);
      rd(2'd2, b); check("R2", "high-only second read", 16'(b), 16'h12);
      wr(2'd3, 8'hF0);
      wr(2'd3, 8'h80);
      rd(2'd2, b); check("R2", "reserved and latch words ignored", 16'(b), 16'h12);
      rd(2'd3, b); check("R5", "control address read", 16'(b), 16'h00);
   endtask

   task automatic t_rate;
      gate[1] = 1'b1;
      wr(2'd3, 8'h74);
      check("R8", "high after control word", 16'(tmr_out[1]), 16'h1);
      wr(2'd1, 8'h04);
      wr(2'd1, 8'h00);
      for (int k = 1; k <= 12; k++) begin
         logic e;
         idle(1);
         e = (k >= 5 && ((k - 5) % 4) == 0) ? 1'b0 : 1'b1;
         check("R8", $sformatf("rate tick %0d", k), 16'(tmr_out[1]), 16'(e));
      end
   endtask

   task automatic t_square;
      gate[2] = 1'b1;
      wr(2'd3, 8'hB6);
      wr(2'd2, 8'h05);
      wr(2'd2, 8'h00);
      check("R9", "high before load", 16'(tmr_out[2]), 16'h1);
      for (int k = 1; k <= 12; k++) begin
         int c;
         logic e;
         idle(1);
         c = 5 - ((k - 1) % 5);
         e = (c > 2) ? 1'b1 : 1'b0;
         check("R9", $sformatf("square tick %0d", k), 16'(tmr_out[2]), 16'(e));
      end
   endtask

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
      addr = 2'b00; din = 8'h00; cnt_en = 1'b1; gate = 3'b111;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      fork
         begin
            t_reset;
            t_chip_select;
            t_uninit;
            t_term;
            t_pointer;
            t_gate;
            t_bcd;
            t_access;
            t_rate;
            t_square;
         end
         begin
            repeat (WD_CYC) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYC);
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule